// File: doc/BRIEF.md
# Prefix-Extended Register Specifier Unit

This block sits in the decode stage of an in-order pipeline and widens the register fields of a fixed 32-bit instruction format. Each base instruction names three sources and one destination with 5-bit fields. A dedicated prefix instruction loads an extension register holding two slots. Each slot carries three upper register-number bits for each of the four fields, a two-lane SIMD attribute and a cache-sector hint. The next one or two base instructions each consume one slot.

For every base instruction the unit emits four 8-bit specifiers, able to address a 256-entry register file, together with a SIMD flag, a sector flag and the original instruction word. Instructions enter through a valid/ready handshake. Results leave from a registered output stage that the consumer can stall. A prefix is absorbed by the unit and produces no output beat. With no slot pending, the unit behaves like the plain base format: upper bits, SIMD and sector are all zero.

Top module: `xreg_spec_unit`

## Requirements
- R1: An accepted word whose bits 31..29 equal 3'b111 is a prefix; it updates the slots and produces no output beat, while any other word produces exactly one beat.
- R2: Each specifier is the slot's 3 upper bits concatenated above the instruction's 5-bit field; the fields sit at rd = bits 29..25, rs1 = bits 18..14, rs3 = bits 13..9, rs2 = bits 4..0.
- R3: A prefix with bit 28 = 0 validates only the first slot, so only the next base instruction is extended.
- R4: A prefix with bit 28 = 1 validates both slots; the first following base instruction uses the first slot (prefix bits 27..14) and the second uses the second slot (bits 13..0), each consumed once.
- R5: With no valid slot, all upper specifier bits, the SIMD flag and the sector flag are output as zero.
- R6: The SIMD flag output equals the simd bit of the slot used (bit 13 of the 14-bit slot field).
- R7: The sector flag output equals the sector bit of the slot used (bit 12 of the slot field); within the slot, bits 11..9, 8..6, 5..3 and 2..0 are the upper bits of rd, rs1, rs2 and rs3.
- R8: A prefix accepted while slots are still pending replaces both slots.
- R9: While an output beat is valid and the consumer is not ready, the beat is held unchanged and in_ready is low.
- R10: After reset no output beat is valid, in_ready is high and no slot is pending.
- R11: The output carries the accepted instruction word unchanged.
- R12: A base instruction accepted at a clock edge appears on the output at that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can accept a word this cycle |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_instr | output | 32 | Instruction word of the beat |
| out_rd | output | 8 | Destination specifier |
| out_rs1 | output | 8 | First source specifier |
| out_rs2 | output | 8 | Second source specifier |
| out_rs3 | output | 8 | Third source specifier |
| out_simd | output | 1 | Two-lane SIMD attribute |
| out_sector | output | 1 | Cache-sector hint |

## Verification
A base instruction's beat is due at the edge that accepts it and then holds for as long as out_ready stays low. A prefix is never due on the output. The scoreboard driver pushes one expected beat per accepted base instruction. It computes that beat from its own slot model at the moment of acceptance. The monitor samples a little after each falling edge and pops only when valid and ready are both high, so stalls neither reorder nor drop items. A directed latency check looks for the beat one cycle after acceptance. Held beats are also compared against a snapshot at each stalled cycle.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

  localparam int HI_W      = 3;
  localparam int LO_W      = 5;
  localparam int SPEC_W    = HI_W + LO_W;
  localparam int SLOT_BITS = 4 * HI_W + 2;
  localparam int NUM_SLOTS = 2;
  localparam int OPC_W     = 3;

  // Base-format register field positions
  localparam int RD_LSB  = 25;
  localparam int RS1_LSB = 14;
  localparam int RS3_LSB = 9;
  localparam int RS2_LSB = 0;

  typedef struct packed {
    logic            vld;
    logic            simd;
    logic            sector;
    logic [HI_W-1:0] up_rd;
    logic [HI_W-1:0] up_rs1;
    logic [HI_W-1:0] up_rs2;
    logic [HI_W-1:0] up_rs3;
  } slot_t;

  // Unpack one slot field of a prefix word
  function automatic slot_t slot_from_bits(input logic [SLOT_BITS-1:0] b,
                                           input logic v);
    slot_t s;
    s.vld    = v;
    s.simd   = b[SLOT_BITS-1];
    s.sector = b[SLOT_BITS-2];
    s.up_rd  = b[4*HI_W-1 -: HI_W];
    s.up_rs1 = b[3*HI_W-1 -: HI_W];
    s.up_rs2 = b[2*HI_W-1 -: HI_W];
    s.up_rs3 = b[HI_W-1:0];
    return s;
  endfunction

  // Build an extended specifier; upper bits forced to zero when unused
  function automatic logic [SPEC_W-1:0] merge_spec(input logic v,
                                                   input logic [HI_W-1:0] hi,
                                                   input logic [LO_W-1:0] lo);
    return v ? {hi, lo} : {{HI_W{1'b0}}, lo};
  endfunction

endpackage

// File: rtl/xreg_prefix_decode.sv
module xreg_prefix_decode
  import xreg_pkg::*;
#(
  parameter int                INSTR_W = 32,
  parameter logic [OPC_W-1:0]  PFX_OPC = 3'b111
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               is_pfx,
  output slot_t              slot_a,
  output slot_t              slot_b
);

  localparam int VAR_BIT = INSTR_W - OPC_W - 1;
  localparam int PAY_TOP = VAR_BIT - 1;

  slot_t slots [NUM_SLOTS];

  assign is_pfx = (instr[INSTR_W-1 -: OPC_W] == PFX_OPC);

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int TOP = PAY_TOP - s * SLOT_BITS;
      if (s == 0) begin : g_first
        assign slots[s] = slot_from_bits(instr[TOP -: SLOT_BITS], 1'b1);
      end else begin : g_later
        assign slots[s] = slot_from_bits(instr[TOP -: SLOT_BITS], instr[VAR_BIT]);
      end
    end
  endgenerate

  assign slot_a = slots[0];
  assign slot_b = slots[1];

endmodule

// File: rtl/xreg_slot_state.sv
module xreg_slot_state
  import xreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  slot_t new_a,
  input  slot_t new_b,
  input  logic  consume,
  output slot_t cur,
  output logic  a_pending,
  output logic  b_pending
);

  slot_t sa, sb;
  logic  use_a, use_b;

  assign use_a = consume && sa.vld;
  assign use_b = consume && !sa.vld && sb.vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa <= '0;
      sb <= '0;
    end else if (load) begin
      sa <= new_a;
      sb <= new_b;
    end else begin
      if (use_a) sa.vld <= 1'b0;
      if (use_b) sb.vld <= 1'b0;
    end
  end

  assign cur       = sa.vld ? sa : sb;
  assign a_pending = sa.vld;
  assign b_pending = sb.vld;

  // R4: first slot is spent first and leaves the second untouched
  a_r4_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    use_a |=> !sa.vld && $stable(sb.vld));
  // R4: second slot is spent once the first is gone
  a_r4_second_slot: assert property (@(posedge clk) disable iff (!rst_n)
    use_b |=> !sb.vld && !sa.vld);
  // R8: a prefix always leaves the first slot pending
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sa.vld);
  // R3: single-slot prefix leaves the second slot empty
  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
    load && !new_b.vld |=> !sb.vld);

endmodule

// File: rtl/xreg_spec_merge.sv
module xreg_spec_merge
  import xreg_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               out_ready,
  input  logic [INSTR_W-1:0] instr,
  input  slot_t              cur,
  output logic               out_valid,
  output logic [INSTR_W-1:0] out_instr,
  output logic [SPEC_W-1:0]  out_rd,
  output logic [SPEC_W-1:0]  out_rs1,
  output logic [SPEC_W-1:0]  out_rs2,
  output logic [SPEC_W-1:0]  out_rs3,
  output logic               out_simd,
  output logic               out_sector
);

  logic [SPEC_W-1:0] nx_rd, nx_rs1, nx_rs2, nx_rs3;

  always_comb begin
    nx_rd  = merge_spec(cur.vld, cur.up_rd,  instr[RD_LSB  +: LO_W]);
    nx_rs1 = merge_spec(cur.vld, cur.up_rs1, instr[RS1_LSB +: LO_W]);
    nx_rs2 = merge_spec(cur.vld, cur.up_rs2, instr[RS2_LSB +: LO_W]);
    nx_rs3 = merge_spec(cur.vld, cur.up_rs3, instr[RS3_LSB +: LO_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_instr  <= '0;
      out_rd     <= '0;
      out_rs1    <= '0;
      out_rs2    <= '0;
      out_rs3    <= '0;
      out_simd   <= 1'b0;
      out_sector <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_instr  <= instr;
      out_rd     <= nx_rd;
      out_rs1    <= nx_rs1;
      out_rs2    <= nx_rs2;
      out_rs3    <= nx_rs3;
      out_simd   <= cur.vld & cur.simd;
      out_sector <= cur.vld & cur.sector;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R12: accepted base instruction is presented one cycle later
  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid && out_instr == $past(instr));
  // R5: without a pending slot the extension bits stay zero
  a_r5_plain: assert property (@(posedge clk) disable iff (!rst_n)
    take && !cur.vld |=> !out_simd && !out_sector &&
      out_rd[SPEC_W-1 -: HI_W] == '0 && out_rs1[SPEC_W-1 -: HI_W] == '0 &&
      out_rs2[SPEC_W-1 -: HI_W] == '0 && out_rs3[SPEC_W-1 -: HI_W] == '0);
  // R2: low specifier bits track the instruction fields
  a_r2_lower: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_rd[LO_W-1:0] == $past(instr[RD_LSB +: LO_W]) &&
             out_rs2[LO_W-1:0] == $past(instr[RS2_LSB +: LO_W]));
  // R9: a stalled beat holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_instr) &&
      $stable(out_rd) && $stable(out_rs1) && $stable(out_rs2) &&
      $stable(out_rs3) && $stable(out_simd) && $stable(out_sector));

endmodule

// File: rtl/xreg_spec_unit.sv
module xreg_spec_unit
  import xreg_pkg::*;
#(
  parameter int               INSTR_W = 32,
  parameter logic [OPC_W-1:0] PFX_OPC = 3'b111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [INSTR_W-1:0] out_instr,
  output logic [SPEC_W-1:0]  out_rd,
  output logic [SPEC_W-1:0]  out_rs1,
  output logic [SPEC_W-1:0]  out_rs2,
  output logic [SPEC_W-1:0]  out_rs3,
  output logic               out_simd,
  output logic               out_sector
);

  logic  is_pfx, accept, pfx_accept, take;
  logic  a_pending, b_pending;
  slot_t new_a, new_b, cur;

  assign in_ready   = !out_valid || out_ready;
  assign accept     = in_valid && in_ready;
  assign pfx_accept = accept && is_pfx;
  assign take       = accept && !is_pfx;

  xreg_prefix_decode #(.INSTR_W(INSTR_W), .PFX_OPC(PFX_OPC)) u_dec (
    .instr  (in_instr),
    .is_pfx (is_pfx),
    .slot_a (new_a),
    .slot_b (new_b)
  );

  xreg_slot_state u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pfx_accept),
    .new_a     (new_a),
    .new_b     (new_b),
    .consume   (take),
    .cur       (cur),
    .a_pending (a_pending),
    .b_pending (b_pending)
  );

  xreg_spec_merge #(.INSTR_W(INSTR_W)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .out_ready  (out_ready),
    .instr      (in_instr),
    .cur        (cur),
    .out_valid  (out_valid),
    .out_instr  (out_instr),
    .out_rd     (out_rd),
    .out_rs1    (out_rs1),
    .out_rs2    (out_rs2),
    .out_rs3    (out_rs3),
    .out_simd   (out_simd),
    .out_sector (out_sector)
  );

  // R1: an absorbed prefix leaves no beat behind
  a_r1_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_accept |=> !out_valid);
  // R10: slots only become pending through a prefix
  a_r10_slot_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pfx_accept) && !$past(a_pending) |-> !a_pending);
  // R4: second slot never outlives into a new pending state without a prefix
  a_r4_b_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pfx_accept) && !$past(b_pending) |-> !b_pending);

endmodule

// File: tb/xreg_spec_unit_tb_top.sv
module xreg_spec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_simd, out_sector;
  logic [31:0] out_instr;
  logic [7:0]  out_rd, out_rs1, out_rs2, out_rs3;

  always #4 clk = ~clk;

  xreg_spec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .out_valid(out_valid), .out_ready(out_ready),
    .out_instr(out_instr), .out_rd(out_rd), .out_rs1(out_rs1),
    .out_rs2(out_rs2), .out_rs3(out_rs3), .out_simd(out_simd),
    .out_sector(out_sector)
  );

  typedef struct packed {
    logic [31:0] w;
    logic [7:0]  rd, rs1, rs2, rs3;
    logic        simd, sec, used;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_fail = 0;
  bit    stall_en = 1'b0;
  bit    done = 1'b0;

  // bench slot model
  bit        mv [2];
  bit [13:0] mb [2];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mkins(input logic [4:0] rd, rs1, rs2, rs3,
                                        input logic [9:0] fill);
    logic [31:0] w;
    w = 32'h8000_0000;
    w[29:25] = rd;  w[18:14] = rs1; w[13:9] = rs3; w[4:0] = rs2;
    w[24:19] = fill[9:4]; w[8:5] = fill[3:0];
    return w;
  endfunction

  function automatic logic [13:0] mkslot(input bit simd, sec,
                                         input logic [2:0] u_rd, u_rs1, u_rs2, u_rs3);
    return {simd, sec, u_rd, u_rs1, u_rs2, u_rs3};
  endfunction

  function automatic logic [31:0] mkpfx(input bit two, input logic [13:0] a, b);
    return {3'b111, two, a, b};
  endfunction

  // model update at acceptance; pushes the expected beat
  task automatic model_accept(input logic [31:0] w, input string tag);
    exp_t e;
    int   k;
    if (w[31:29] == 3'b111) begin
      mb[0] = w[27:14]; mb[1] = w[13:0];
      mv[0] = 1'b1;     mv[1] = w[28];
    end else begin
      k = mv[0] ? 0 : (mv[1] ? 1 : -1);
      e.w = w; e.used = (k >= 0);
      e.rd  = {3'b000, w[29:25]};
      e.rs1 = {3'b000, w[18:14]};
      e.rs2 = {3'b000, w[4:0]};
      e.rs3 = {3'b000, w[13:9]};
      e.simd = 1'b0; e.sec = 1'b0;
      if (k >= 0) begin
        e.rd[7:5]  = 3'((mb[k] >> 9) & 14'h7);
        e.rs1[7:5] = 3'((mb[k] >> 6) & 14'h7);
        e.rs2[7:5] = 3'((mb[k] >> 3) & 14'h7);
        e.rs3[7:5] = 3'(mb[k] & 14'h7);
        e.simd = mb[k][13];
        e.sec  = mb[k][12];
        mv[k] = 1'b0;
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  task automatic issue(input logic [31:0] w, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_instr = w;
    #2;
    while (!in_ready) begin
      @(negedge clk); #2;
    end
    model_accept(w, tag);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // consumer back-pressure
  always @(negedge clk) out_ready = stall_en ? 1'($urandom_range(0, 1)) : 1'b1;

  // monitor / scoreboard
  initial begin
    bit          held;
    logic [63:0] snap;
    exp_t        e;
    string       t;
    held = 1'b0;
    forever begin
      @(negedge clk); #2;
      if (rst_n && out_valid) begin
        if (held)
          chk({out_instr, out_rd, out_rs1, out_rs2, out_rs3} == {snap, 40'h0} >> 0 ?
              1'b1 : ({out_instr, out_rd, out_rs1, out_rs2[7:0]} == snap),
              "R9", "held beat", {out_instr, out_rd, out_rs1, out_rs2}, snap);
        if (!out_ready) begin
          chk(!in_ready, "R9", "in_ready while stalled", 64'(in_ready), 64'h0);
          snap = {out_instr, out_rd, out_rs1, out_rs2};
          held = 1'b1;
        end else begin
          held = 1'b0;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1", "unexpected beat", 64'(out_instr), 64'h0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_instr == e.w, "R11", "instr", 64'(out_instr), 64'(e.w));
            chk({out_rd, out_rs1, out_rs2, out_rs3} == {e.rd, e.rs1, e.rs2, e.rs3},
                e.used ? t : "R5", "specifiers",
                64'({out_rd, out_rs1, out_rs2, out_rs3}),
                64'({e.rd, e.rs1, e.rs2, e.rs3}));
            chk(out_simd == e.simd, e.used ? "R6" : "R5", "simd",
                64'(out_simd), 64'(e.simd));
            chk(out_sector == e.sec, e.used ? "R7" : "R5", "sector",
                64'(out_sector), 64'(e.sec));
          end
        end
      end else begin
        held = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    mv[0] = 1'b0; mv[1] = 1'b0; mb[0] = '0; mb[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R10: reset state
    chk(!out_valid, "R10", "out_valid after reset", 64'(out_valid), 64'h0);
    chk(in_ready, "R10", "in_ready after reset", 64'(in_ready), 64'h1);

    // R12: one-cycle latency
    issue(mkins(5'd3, 5'd4, 5'd5, 5'd6, 10'h155), "R12");
    idle(0);
    #2;
    chk(out_valid, "R12", "beat one cycle after accept", 64'(out_valid), 64'h1);
    idle(2);
    chk(!out_valid, "R12", "beat gone after handshake", 64'(out_valid), 64'h0);

    // R1: near-prefix opcode is an ordinary instruction
    issue(32'hD000_0000 | 32'(mkins(5'd9, 5'd1, 5'd2, 5'd3, 10'h0) & 32'h3FFF_FFFF), "R1");
    // R5: plain instruction, no slot
    issue(mkins(5'd31, 5'd0, 5'd17, 5'd8, 10'h3FF), "R5");

    // R3: single-slot prefix
    issue(mkpfx(1'b0, mkslot(1'b1, 1'b0, 3'd7, 3'd1, 3'd2, 3'd3),
                      mkslot(1'b1, 1'b1, 3'd5, 3'd5, 3'd5, 3'd5)), "R3");
    issue(mkins(5'd1, 5'd2, 5'd3, 5'd4, 10'h0), "R3");
    issue(mkins(5'd1, 5'd2, 5'd3, 5'd4, 10'h0), "R3");

    // R4: two-slot prefix, slots in order, then none
    issue(mkpfx(1'b1, mkslot(1'b0, 1'b1, 3'd4, 3'd3, 3'd2, 3'd1),
                      mkslot(1'b1, 1'b0, 3'd6, 3'd0, 3'd7, 3'd2)), "R4");
    issue(mkins(5'd10, 5'd11, 5'd12, 5'd13, 10'h2AA), "R4");
    issue(mkins(5'd20, 5'd21, 5'd22, 5'd23, 10'h111), "R4");
    issue(mkins(5'd30, 5'd29, 5'd28, 5'd27, 10'h0F0), "R4");

    // R8: new prefix overwrites pending slots
    issue(mkpfx(1'b1, mkslot(1'b1, 1'b1, 3'd1, 3'd1, 3'd1, 3'd1),
                      mkslot(1'b1, 1'b1, 3'd2, 3'd2, 3'd2, 3'd2)), "R8");
    issue(mkins(5'd5, 5'd6, 5'd7, 5'd8, 10'h0), "R8");
    issue(mkpfx(1'b0, mkslot(1'b0, 1'b1, 3'd6, 3'd5, 3'd4, 3'd3), 14'h3FFF), "R8");
    issue(mkins(5'd5, 5'd6, 5'd7, 5'd8, 10'h0), "R8");
    issue(mkins(5'd5, 5'd6, 5'd7, 5'd8, 10'h0), "R8");
    // R8: back-to-back prefixes, the later one wins
    issue(mkpfx(1'b1, 14'h3FFF, 14'h3FFF), "R8");
    issue(mkpfx(1'b0, mkslot(1'b1, 1'b0, 3'd3, 3'd0, 3'd0, 3'd7), 14'h0), "R8");
    issue(mkins(5'd0, 5'd31, 5'd1, 5'd30, 10'h0), "R8");
    issue(mkins(5'd0, 5'd31, 5'd1, 5'd30, 10'h0), "R8");
    idle(3);

    // R2/R9: random stream under back-pressure
    stall_en = 1'b1;
    for (int i = 0; i < 120; i++) begin
      w = $urandom;
      if (($urandom % 4) == 0) begin
        w[31:29] = 3'b111;
      end else if (w[31:29] == 3'b111) begin
        w[31] = 1'b0;
      end
      issue(w, "R2");
    end
    stall_en = 1'b0;
    idle(6);

    // R1: every expected beat seen, nothing extra
    chk(exp_q.size() == 0, "R1", "scoreboard drained", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule